// File: doc/BRIEF.md
# Conversion Auto-Trigger Selector

This block picks one of eight event sources with a 3-bit select field and turns a rising edge of the chosen source into a one-cycle start pulse for an analog-to-digital converter. Seven of the sources are level flags from the surrounding timers, the comparator and the external interrupt logic. The eighth choice is free running, which restarts the converter each time its own conversion-complete flag rises.

Edges are found on the value after the multiplexer, so changing the select field takes effect on the same cycle. Moving from a source that reads 0 to one that reads 1 therefore counts as an edge and starts a conversion. The one exception is a move into free running, which never starts a conversion, whatever state the conversion-complete flag is in. A start is issued only when auto-triggering and the converter are both enabled and no conversion is running. A start that arrives while a conversion is running is dropped, not held for later.

Top module: `adc_trigger_select`

## Requirements
- R1: `trig_sel` value 0 selects `conv_done`. Value n from 1 to 7 selects `event_flags[n-1]`, with bit 0 comparator, bit 1 external interrupt 0, bit 2 timer 0 compare A, bit 3 timer 0 overflow, bit 4 timer 1 compare B, bit 5 timer 1 overflow and bit 6 timer 1 capture.
- R2: When the selected value is 1 on a clock edge and was 0 on the previous edge, `start_conv` is high for the cycle that follows, provided `auto_en` and `adc_en` are high and `busy` is low on that edge.
- R3: If `trig_sel` changes from a nonzero source that reads 0 to a nonzero source that reads 1, this counts as a rising edge and produces a start.
- R4: On an edge where `trig_sel` becomes 0 after having been nonzero, no start is produced, even when `conv_done` is high.
- R5: While `auto_en` is low, no start is produced. Edge history is still tracked, so raising `auto_en` while the selected flag is already high produces no start.
- R6: While `adc_en` is low, no start is produced.
- R7: An edge that arrives while `busy` is high is dropped and is not produced later.
- R8: `start_conv` is low during reset and never stays high for two cycles in a row. Edge history resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_sel | input | 3 | Source select |
| event_flags | input | 7 | Level flags of the seven event sources |
| conv_done | input | 1 | Conversion-complete flag |
| auto_en | input | 1 | Auto-trigger enable |
| adc_en | input | 1 | Converter enable |
| busy | input | 1 | A conversion is running |
| start_conv | output | 1 | One-cycle conversion start |

## Verification
The assertions check on every cycle that the pulse never lasts two cycles, and that a cycle with auto-triggering off, the converter off, busy high or a move into free running is never followed by a start. Whether each select code reaches the correct flag, and whether a source switch or an enable raised during a high flag is handled correctly, depends on history across several cycles. Only the bench's reference model can show these, by comparing the pulse with the expected value under directed and random stimulus.

// File: rtl/adc_trigger_select.sv
module adc_trigger_select #(
  parameter int NSRC = 7,
  localparam int SW = $clog2(NSRC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] trig_sel,
  input  logic [NSRC-1:0] event_flags,
  input  logic          conv_done,
  input  logic          auto_en,
  input  logic          adc_en,
  input  logic          busy,
  output logic          start_conv
);

  logic [NSRC:0] src_vec;
  logic          sel_val;
  logic          sel_val_q;
  logic [SW-1:0] sel_q;
  logic          entering_free;
  logic          edge_seen;

  assign src_vec       = {event_flags, conv_done};
  assign sel_val       = src_vec[trig_sel];
  assign entering_free = (trig_sel == '0) && (sel_q != '0);
  assign edge_seen     = sel_val && !sel_val_q && !entering_free;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_val_q  <= 1'b0;
      sel_q      <= '0;
      start_conv <= 1'b0;
    end else begin
      sel_val_q  <= sel_val;
      sel_q      <= trig_sel;
      start_conv <= edge_seen && auto_en && adc_en && !busy;
    end
  end

endmodule

module adc_trigger_select_chk #(
  parameter int NSRC = 7,
  localparam int SW = $clog2(NSRC + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [SW-1:0] trig_sel,
  input logic          auto_en,
  input logic          adc_en,
  input logic          busy,
  input logic          start_conv
);

  logic [SW-1:0] sel_d;
  always_ff @(posedge clk) begin
    if (!rst_n) sel_d <= '0;
    else        sel_d <= trig_sel;
  end

  assert_reset_low_R8: assert property (@(posedge clk) !rst_n |=> !start_conv);
  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_conv |=> !start_conv);
  assert_auto_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |=> !start_conv);
  assert_adc_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_en |=> !start_conv);
  assert_busy_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !start_conv);
  assert_free_switch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_sel == '0 && sel_d != '0) |=> !start_conv);

endmodule

bind adc_trigger_select adc_trigger_select_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_sel(trig_sel), .auto_en(auto_en),
  .adc_en(adc_en), .busy(busy), .start_conv(start_conv)
);

// File: tb/adc_trigger_select_bench.sv
`timescale 1ns/1ps
module adc_trigger_select_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] sel = '0;
  logic [6:0] flags = '0;
  logic done = 1'b0, aen = 1'b0, en = 1'b0, bsy = 1'b0;
  logic start;
  int vectors = 0, errors = 0;
  logic m_prev_val, m_prev_sel_nz;

  always #2 clk = ~clk;

  adc_trigger_select u_adc_trigger_select (
    .clk(clk), .rst_n(rst_n), .trig_sel(sel), .event_flags(flags),
    .conv_done(done), .auto_en(aen), .adc_en(en), .busy(bsy), .start_conv(start)
  );

  function automatic logic pick(logic [2:0] s, logic [6:0] f, logic d);
    if (s == 3'd0) return d;
    return f[s - 3'd1];
  endfunction

  function automatic logic expect_start(logic v, logic pv, logic [2:0] s, logic psnz,
                                        logic a, logic e, logic b);
    if (s == 3'd0 && psnz) return 1'b0;
    return v && !pv && a && e && !b;
  endfunction

  task automatic step(string tag);
    logic v, ex;
    @(posedge clk);
    v  = pick(sel, flags, done);
    ex = expect_start(v, m_prev_val, sel, m_prev_sel_nz, aen, en, bsy);
    m_prev_val = v;
    m_prev_sel_nz = (sel != 3'd0);
    @(negedge clk);
    vectors++;
    if (start !== ex) begin
      errors++;
      $display("FAIL %s: start_conv=%b expected %b (sel=%0d flags=%b done=%b)",
               tag, start, ex, sel, flags, done);
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    $urandom(1234);
    m_prev_val = 1'b0;
    m_prev_sel_nz = 1'b0;
    repeat (3) @(negedge clk);
    vectors++;
    if (start !== 1'b0) begin
      errors++;
      $display("FAIL R8: start_conv=%b in reset expected 0", start);
    end
    rst_n = 1'b1;
    aen = 1'b1; en = 1'b1;
    step("R8");

    for (int s = 1; s < 8; s++) begin
      sel = 3'(s); flags = '0; step("R1");
      flags = ~(7'd1 << (s - 1)); step("R1");
      flags = '1; step("R1");
      step("R1");
      flags = '0; step("R1");
    end

    sel = 3'd1; flags = 7'b0010000; step("R3");
    sel = 3'd5; step("R3");
    sel = 3'd2; flags = '0; step("R3");

    sel = 3'd4; done = 1'b1; step("R4");
    sel = 3'd0; step("R4");
    done = 1'b0; step("R2");
    done = 1'b1; step("R2");
    done = 1'b0; step("R2");

    sel = 3'd6; aen = 1'b0; step("R5");
    flags[5] = 1'b1; step("R5");
    aen = 1'b1; step("R5");
    flags[5] = 1'b0; step("R5");

    en = 1'b0; flags[5] = 1'b1; step("R6");
    en = 1'b1; flags[5] = 1'b0; step("R6");

    bsy = 1'b1; flags[5] = 1'b1; step("R7");
    bsy = 1'b0; step("R7");
    step("R7");
    flags = '0; step("R7");

    flags[6] = 1'b1; sel = 3'd7; step("R8");
    step("R8");

    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 8 == 0) sel = 3'($urandom);
      for (int b = 0; b < 7; b++) if ($urandom % 4 == 0) flags[b] = ~flags[b];
      if ($urandom % 4 == 0) done = ~done;
      aen = ($urandom % 8) != 0;
      en  = ($urandom % 8) != 0;
      bsy = ($urandom % 4) == 0;
      step("R2");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule